// File: doc/BRIEF.md
# Quad Potentiometer Serial Command Slave

This block is the serial front end of a four-channel digital potentiometer. It listens on a four-wire SPI-mode link with an extra pause input, and it oversamples that link with the system clock. A transaction opens when chip select falls. The first byte names the device type and carries a two-bit address, which must equal two strap pins. The second byte carries an opcode, a register index and a pot index. What follows depends on the opcode: nothing, one data byte in or out, or an open-ended stream of single-step wiper moves.

The block owns no wiper or data storage. Each accepted command leaves as a one-cycle strobe, together with the opcode, the pot index, the register index, the data byte and a step direction. A separate register bank acts on these strobes. For a read, the bank returns the addressed byte on `rd_data`, and the slave shifts that byte out on SO. The status read is answered locally from the `wip` input.

Top module: `qpot_spi_slave`

## Requirements
- R1: After reset the slave drives no data (`spi_so_oe` low) and issues no strobe. It accepts no command until it has seen chip select go from high to low, so a frame sent while select was already low at reset is ignored.
- R2: The first byte, taken MSB first, must read `0101` in its upper nibble, `00` in bits 3..2, and the value of `addr_strap` in bits 1..0. Any other first byte makes the slave ignore the rest of the frame: no strobe and no SO drive.
- R3: In the second byte, bits 7..4 are the opcode, bits 3..2 the register index and bits 1..0 the pot index. Every strobe presents the opcode on `cmd_op`, bits 3..2 on `cmd_reg` and bits 1..0 on `cmd_pot`.
- R4: Opcodes 1010 (write wiper) and 1100 (write data register) take a third byte. A single strobe is issued after its eighth bit, and that byte appears on `cmd_data`.
- R5: Opcodes 1101 (data register to wiper), 1110 (wiper to data register), 0001 (all pots, data register to wiper) and 1000 (all pots, wiper to data register) end with the second byte. Each issues one strobe after the sixteenth bit.
- R6: Opcodes 1001 (read wiper) and 1011 (read data register) issue one strobe after the sixteenth bit. The bank must present the addressed byte on `rd_data` in the cycle after that strobe. The slave then drives this byte on SO, MSB first, updating SO only after falling SCK edges.
- R7: Opcode 0101 (status) issues no strobe. It returns on SO the byte whose bits 7..1 are zero and whose bit 0 is `wip`.
- R8: Opcode 0010 issues no strobe for the instruction byte. After it, every rising SCK edge issues one strobe with `cmd_op` = 0010, the pot index, and `cmd_up` equal to SI at that edge. This continues without limit until chip select rises.
- R9: Any other opcode issues no strobe and no SO drive for the rest of the frame.
- R10: When `spi_hold_n` goes low while SCK is low, the transfer pauses. SCK edges are ignored and SO is released. When `spi_hold_n` goes high again while SCK is low, the frame continues from the bit where it stopped.
- R11: When chip select rises, SO is released and any partly received frame is dropped without a strobe. The next frame starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data from the host |
| spi_hold_n | input | 1 | Pause request, active low |
| addr_strap | input | 2 | Device address straps |
| wip | input | 1 | Store-in-progress flag, returned by the status read |
| rd_data | input | 8 | Read byte from the register bank, valid the cycle after a read strobe |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | SO output enable (high = drive) |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 4 | Opcode of the strobed command |
| cmd_pot | output | 2 | Pot index |
| cmd_reg | output | 2 | Data register index |
| cmd_data | output | 8 | Write data byte |
| cmd_up | output | 1 | Step direction for opcode 0010 (1 = up) |

## Verification
A bit counter that slips by one shows up within the same frame. The strobe then carries rotated opcode or index fields, or it lands on the wrong edge, and the bench compares every field of the strobe before the next frame begins. A phase machine stuck in the wrong state shows at the ports in three ways: a strobe that should not appear, a missing strobe, or SO driven during an ignored frame. Because the bench reads SO before every rising edge, a wrong shift position or a wrong pause state reveals itself as a mismatch in the very bit where it arises.

// File: rtl/qpot_spi_pkg.sv
package qpot_spi_pkg;

  localparam int OP_W = 4;

  typedef enum logic [3:0] {
    OP_GDR2W  = 4'b0001,
    OP_STEP   = 4'b0010,
    OP_RDSTAT = 4'b0101,
    OP_GW2DR  = 4'b1000,
    OP_RDWIP  = 4'b1001,
    OP_WRWIP  = 4'b1010,
    OP_RDDR   = 4'b1011,
    OP_WRDR   = 4'b1100,
    OP_DR2W   = 4'b1101,
    OP_W2DR   = 4'b1110
  } op_e;

  typedef enum logic [2:0] {
    LEN_NONE,
    LEN_SHORT,
    LEN_WRITE,
    LEN_READ,
    LEN_STREAM
  } len_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_INSTR,
    ST_DIN,
    ST_DOUT,
    ST_STEP,
    ST_DONE
  } st_e;

endpackage

// File: rtl/qpot_spi_sync.sv
module qpot_spi_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          pipe[s] <= INIT;
        end else if (s == 0) begin
          pipe[s] <= d;
        end else begin
          pipe[s] <= pipe[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/qpot_spi_hold.sv
module qpot_spi_hold (
  input  logic clk,
  input  logic rst,
  input  logic cs_q,
  input  logic sck_q,
  input  logic hold_q,
  output logic paused
);

  // pause state may only move while the serial clock is low
  always_ff @(posedge clk) begin
    if (rst || cs_q) begin
      paused <= 1'b0;
    end else if (!sck_q) begin
      paused <= !hold_q;
    end
  end

  // R10: pause changes only across a low SCK level (unless select drops)
  a_r10_pause_on_low_sck: assert property (@(posedge clk) disable iff (rst)
    (paused != $past(paused)) && !$past(cs_q) |-> !$past(sck_q));

endmodule

// File: rtl/qpot_spi_opdec.sv
module qpot_spi_opdec
  import qpot_spi_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output len_e            len,
  output logic            to_bank
);

  always_comb begin
    len     = LEN_NONE;
    to_bank = 1'b0;
    case (op)
      OP_GDR2W, OP_GW2DR, OP_DR2W, OP_W2DR: len = LEN_SHORT;
      OP_WRWIP, OP_WRDR:                    len = LEN_WRITE;
      OP_RDWIP, OP_RDDR: begin
        len     = LEN_READ;
        to_bank = 1'b1;
      end
      OP_RDSTAT:                            len = LEN_READ;
      OP_STEP:                              len = LEN_STREAM;
      default:                              len = LEN_NONE;
    endcase
  end

endmodule

// File: rtl/qpot_spi_frame.sv
module qpot_spi_frame
  import qpot_spi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int POT_W  = 2,
  parameter int REG_W  = 2,
  parameter logic [3:0] ID_TYPE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_q,
  input  logic              sck_q,
  input  logic              si_q,
  input  logic              paused,
  input  logic [ADDR_W-1:0] strap,
  input  logic              wip,
  input  logic [DATA_W-1:0] rd_data,
  output logic              cmd_valid,
  output logic [OP_W-1:0]   cmd_op,
  output logic [POT_W-1:0]  cmd_pot,
  output logic [REG_W-1:0]  cmd_reg,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_up,
  output logic              so,
  output logic              so_oe
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam int PAD_W = DATA_W - OP_W - ADDR_W;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  st_e               st;
  logic              cs_prev, sck_prev, armed;
  logic              cs_fall, sck_rise, sck_fall;
  logic [DATA_W-2:0] shreg;
  logic [DATA_W-1:0] byte_now, instr_q, out_sh;
  logic [CNT_W-1:0]  bitcnt;
  logic              byte_done, id_ok, drive_q, ld_is_stat;
  logic [1:0]        ld_pipe;
  logic [OP_W-1:0]   op_now;
  len_e              len_now;
  logic              bank_now;

  assign cs_fall   = cs_prev & ~cs_q;
  assign sck_rise  = sck_q & ~sck_prev & ~paused;
  assign sck_fall  = ~sck_q & sck_prev & ~paused;
  assign byte_now  = {shreg, si_q};
  assign byte_done = sck_rise && (bitcnt == LAST_BIT);
  assign op_now    = byte_now[DATA_W-1 -: OP_W];
  assign id_ok     = (byte_now[DATA_W-1 -: OP_W] == ID_TYPE) &&
                     (byte_now[ADDR_W +: PAD_W] == '0) &&
                     (byte_now[ADDR_W-1:0] == strap);

  qpot_spi_opdec u_opdec (
    .op      (op_now),
    .len     (len_now),
    .to_bank (bank_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cs_prev    <= 1'b0;
      sck_prev   <= 1'b0;
      armed      <= 1'b0;
      shreg      <= '0;
      bitcnt     <= '0;
      instr_q    <= '0;
      out_sh     <= '0;
      drive_q    <= 1'b0;
      ld_pipe    <= '0;
      ld_is_stat <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd_op     <= '0;
      cmd_pot    <= '0;
      cmd_reg    <= '0;
      cmd_data   <= '0;
      cmd_up     <= 1'b0;
      so         <= 1'b0;
      so_oe      <= 1'b0;
    end else begin
      cs_prev   <= cs_q;
      sck_prev  <= sck_q;
      cmd_valid <= 1'b0;
      ld_pipe   <= {ld_pipe[0], 1'b0};
      so_oe     <= drive_q & ~paused & ~cs_q;
      if (cs_fall) armed <= 1'b1;

      if (cs_q) begin
        st      <= ST_IDLE;
        bitcnt  <= '0;
        drive_q <= 1'b0;
        ld_pipe <= '0;
      end else if (cs_fall) begin
        st      <= ST_ID;
        bitcnt  <= '0;
        drive_q <= 1'b0;
      end else begin
        if (sck_rise && st != ST_IDLE && st != ST_DONE) begin
          shreg  <= byte_now[DATA_W-2:0];
          bitcnt <= bitcnt + 1'b1;
        end
        case (st)
          ST_ID: if (byte_done) st <= id_ok ? ST_INSTR : ST_DONE;
          ST_INSTR: if (byte_done) begin
            instr_q <= byte_now;
            cmd_op  <= op_now;
            cmd_reg <= byte_now[POT_W +: REG_W];
            cmd_pot <= byte_now[POT_W-1:0];
            case (len_now)
              LEN_SHORT: begin
                cmd_valid <= 1'b1;
                st        <= ST_DONE;
              end
              LEN_WRITE:  st <= ST_DIN;
              LEN_READ: begin
                cmd_valid  <= bank_now;
                ld_is_stat <= !bank_now;
                ld_pipe    <= 2'b01;
                st         <= ST_DOUT;
              end
              LEN_STREAM: st <= ST_STEP;
              default:    st <= ST_DONE;
            endcase
          end
          ST_DIN: if (byte_done) begin
            cmd_valid <= 1'b1;
            cmd_op    <= instr_q[DATA_W-1 -: OP_W];
            cmd_reg   <= instr_q[POT_W +: REG_W];
            cmd_pot   <= instr_q[POT_W-1:0];
            cmd_data  <= byte_now;
            st        <= ST_DONE;
          end
          ST_STEP: if (sck_rise) begin
            cmd_valid <= 1'b1;
            cmd_op    <= OP_STEP;
            cmd_pot   <= instr_q[POT_W-1:0];
            cmd_reg   <= instr_q[POT_W +: REG_W];
            cmd_up    <= si_q;
          end
          ST_DOUT: begin
            if (ld_pipe[1]) begin
              out_sh <= ld_is_stat ? {{(DATA_W-1){1'b0}}, wip} : rd_data;
            end else if (sck_fall) begin
              so      <= out_sh[DATA_W-1];
              out_sh  <= {out_sh[DATA_W-2:0], 1'b0};
              drive_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: SO released once select is high
  a_r11_release_when_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_q |=> !so_oe);
  // R10: SO released during a pause
  a_r10_release_when_paused: assert property (@(posedge clk) disable iff (rst)
    paused |=> !so_oe);
  // R1: nothing is strobed before a select edge was seen
  a_r1_silent_until_armed: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !cmd_valid);
  // R6: SO moves only after a falling serial clock edge
  a_r6_so_on_falling_edge: assert property (@(posedge clk) disable iff (rst)
    (so != $past(so)) |-> $past(sck_fall));
  // R9: only defined opcodes are ever strobed
  a_r9_defined_ops_only: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_op inside {OP_GDR2W, OP_STEP, OP_GW2DR, OP_RDWIP, OP_WRWIP,
                                  OP_RDDR, OP_WRDR, OP_DR2W, OP_W2DR}));
  // R2: a strobe comes only from a phase reached through a matching first byte
  a_r2_strobe_after_id: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ($past(st) inside {ST_INSTR, ST_DIN, ST_STEP}));
  // R8: step strobes come only from the streaming phase
  a_r8_step_from_stream: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && (cmd_op == OP_STEP) |-> $past(st == ST_STEP));

endmodule

// File: rtl/qpot_spi_slave.sv
module qpot_spi_slave #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int POT_W = 2,
  parameter int REG_W = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [3:0] ID_TYPE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  input  logic              spi_hold_n,
  input  logic [ADDR_W-1:0] addr_strap,
  input  logic              wip,
  input  logic [DATA_W-1:0] rd_data,
  output logic              spi_so,
  output logic              spi_so_oe,
  output logic              cmd_valid,
  output logic [3:0]        cmd_op,
  output logic [POT_W-1:0]  cmd_pot,
  output logic [REG_W-1:0]  cmd_reg,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_up
);

  localparam int NSIG = 4;
  // bit order {cs, sck, si, hold}; select starts low so a held-low select is no edge
  localparam logic [NSIG-1:0] SYNC_INIT = 4'b0001;

  logic [NSIG-1:0] raw, synced;
  logic            cs_q, sck_q, si_q, hold_q, paused;

  assign raw = {spi_cs_n, spi_sck, spi_si, spi_hold_n};
  assign {cs_q, sck_q, si_q, hold_q} = synced;

  qpot_spi_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .INIT(SYNC_INIT)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (synced)
  );

  qpot_spi_hold u_hold (
    .clk    (clk),
    .rst    (rst),
    .cs_q   (cs_q),
    .sck_q  (sck_q),
    .hold_q (hold_q),
    .paused (paused)
  );

  qpot_spi_frame #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .POT_W  (POT_W),
    .REG_W  (REG_W),
    .ID_TYPE(ID_TYPE)
  ) u_frame (
    .clk       (clk),
    .rst       (rst),
    .cs_q      (cs_q),
    .sck_q     (sck_q),
    .si_q      (si_q),
    .paused    (paused),
    .strap     (addr_strap),
    .wip       (wip),
    .rd_data   (rd_data),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_pot   (cmd_pot),
    .cmd_reg   (cmd_reg),
    .cmd_data  (cmd_data),
    .cmd_up    (cmd_up),
    .so        (spi_so),
    .so_oe     (spi_so_oe)
  );

endmodule

// File: tb/qpot_spi_slave_tb_top.sv
`timescale 1ns/1ps
module qpot_spi_slave_tb_top;

  localparam int HALF = 64;
  localparam int NV = 13;
  // {id, instr, data, expected rx, bytes, strobe expected, read}
  localparam logic [35:0] VEC [NV] = '{
    {8'h52, 8'hA1, 8'h3C, 8'h00, 2'd3, 1'b1, 1'b0},
    {8'h52, 8'hCB, 8'h5A, 8'h00, 2'd3, 1'b1, 1'b0},
    {8'h52, 8'h92, 8'h00, 8'h52, 2'd3, 1'b1, 1'b1},
    {8'h52, 8'hB4, 8'h00, 8'hA1, 2'd3, 1'b1, 1'b1},
    {8'h52, 8'hDD, 8'h00, 8'h00, 2'd2, 1'b1, 1'b0},
    {8'h52, 8'hE2, 8'h00, 8'h00, 2'd2, 1'b1, 1'b0},
    {8'h52, 8'h18, 8'h00, 8'h00, 2'd2, 1'b1, 1'b0},
    {8'h52, 8'h84, 8'h00, 8'h00, 2'd2, 1'b1, 1'b0},
    {8'h51, 8'hA1, 8'h77, 8'h00, 2'd3, 1'b0, 1'b0},
    {8'h62, 8'hA1, 8'h77, 8'h00, 2'd3, 1'b0, 1'b0},
    {8'h56, 8'hA1, 8'h77, 8'h00, 2'd3, 1'b0, 1'b0},
    {8'h52, 8'h30, 8'h00, 8'h00, 2'd3, 1'b0, 1'b0},
    {8'h52, 8'h50, 8'h00, 8'h01, 2'd3, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic wip = 1'b1;
  logic [7:0] rd_data = 8'h00;
  logic so, so_oe, cmd_valid, cmd_up;
  logic [3:0] cmd_op;
  logic [1:0] cmd_pot, cmd_reg;
  logic [7:0] cmd_data;

  int n_chk = 0, n_err = 0, m_cnt = 0;
  logic [3:0] m_op;
  logic [1:0] m_pot, m_reg;
  logic [7:0] m_data, m_up_hist;
  logic oe_any;

  always #4 clk = ~clk;

  qpot_spi_slave dut_i (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_hold_n(hold_n), .addr_strap(2'b10), .wip(wip), .rd_data(rd_data),
    .spi_so(so), .spi_so_oe(so_oe), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data), .cmd_up(cmd_up)
  );

  // bank model: records strobes, answers reads the cycle after
  always @(negedge clk) begin
    if (cmd_valid) begin
      m_cnt++;
      m_op = cmd_op; m_pot = cmd_pot; m_reg = cmd_reg; m_data = cmd_data;
      if (cmd_op == 4'b0010) m_up_hist = {m_up_hist[6:0], cmd_up};
      if (cmd_op == 4'b1001) rd_data = 8'h50 + 8'(cmd_pot);
      if (cmd_op == 4'b1011) rd_data = 8'hA0 + 8'({cmd_pot, cmd_reg});
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic r);
    si = b;
    #(HALF);
    r = so;
    if (so_oe) oe_any = 1'b1;
    sck = 1'b1;
    #(HALF);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) bit_x(tx[i], rx[i]);
  endtask

  task automatic sel;
    oe_any = 1'b0;
    cs_n = 1'b0;
    #(HALF);
  endtask

  task automatic desel;
    #(HALF);
    cs_n = 1'b1;
    #(8*HALF);
  endtask

  initial begin
    #(2_000_000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    logic r;
    int c0;
    m_up_hist = '0;
    oe_any = 1'b0;
    #(80);
    rst = 1'b0;
    #(40);
    check(so_oe == 1'b0, "R1 reset so_oe", 32'(so_oe), 0);
    check(cmd_valid == 1'b0, "R1 reset strobe", 32'(cmd_valid), 0);
    // select already low at reset: frame must be ignored
    xfer(8'h52, rx); xfer(8'hA1, rx); xfer(8'h3C, rx);
    check(m_cnt == 0, "R1 no command before select edge", 32'(m_cnt), 0);
    cs_n = 1'b1;
    #(8*HALF);

    for (int v = 0; v < NV; v++) begin
      logic [35:0] e;
      string tag;
      e = VEC[v];
      tag = e[1] ? (e[3:2] == 2'd3 ? (e[0] ? "R6" : "R4") : "R5") :
            (e[0] ? "R7" : (e[35:28] != 8'h52 ? "R2" : "R9"));
      c0 = m_cnt;
      sel();
      xfer(e[35:28], rx);
      xfer(e[27:20], rx);
      if (e[3:2] == 2'd3) xfer(e[19:12], rx);
      desel();
      check((m_cnt - c0) == 32'(e[1]), {tag, " strobe count"}, 32'(m_cnt - c0), 32'(e[1]));
      if (e[1]) begin
        check({m_op, m_reg, m_pot} == e[27:20], {tag, " R3 fields"}, 32'({m_op, m_reg, m_pot}), 32'(e[27:20]));
        if (e[3:2] == 2'd3 && !e[0])
          check(m_data == e[19:12], {tag, " write data"}, 32'(m_data), 32'(e[19:12]));
      end
      if (e[0]) check(rx == e[11:4] && oe_any, {tag, " read byte"}, 32'(rx), 32'(e[11:4]));
      else check(!oe_any, {tag, " SO not driven"}, 32'(oe_any), 0);
    end

    // R8: step stream
    c0 = m_cnt;
    sel();
    xfer(8'h52, rx); xfer(8'h21, rx);
    bit_x(1'b1, r); bit_x(1'b1, r); bit_x(1'b0, r); bit_x(1'b1, r); bit_x(1'b0, r);
    desel();
    check(m_cnt - c0 == 5, "R8 step count", 32'(m_cnt - c0), 5);
    check(m_up_hist[4:0] == 5'b11010, "R8 step directions", 32'(m_up_hist[4:0]), 32'h1A);
    check(m_op == 4'b0010 && m_pot == 2'd1, "R8 step op/pot", 32'({m_op, m_pot}), 32'h9);

    // R10: pause in the middle of a read
    c0 = m_cnt;
    sel();
    xfer(8'h52, rx); xfer(8'h93, rx);
    bit_x(1'b0, rx[7]); bit_x(1'b0, rx[6]); bit_x(1'b0, rx[5]);
    hold_n = 1'b0;
    #(HALF);
    check(so_oe == 1'b0, "R10 SO released in pause", 32'(so_oe), 0);
    bit_x(1'b1, r); bit_x(1'b0, r);
    check(so_oe == 1'b0, "R10 SO still released", 32'(so_oe), 0);
    hold_n = 1'b1;
    #(HALF);
    for (int i = 4; i >= 0; i--) bit_x(1'b0, rx[i]);
    desel();
    check(rx == 8'h53, "R10 read resumes intact", 32'(rx), 32'h53);
    check(m_cnt - c0 == 1, "R10 single strobe", 32'(m_cnt - c0), 1);

    // R11: abort a write mid-byte
    c0 = m_cnt;
    sel();
    xfer(8'h52, rx); xfer(8'hA1, rx);
    bit_x(1'b1, r); bit_x(1'b0, r); bit_x(1'b1, r); bit_x(1'b1, r);
    desel();
    check(m_cnt == c0, "R11 aborted write dropped", 32'(m_cnt - c0), 0);
    // R11: abort a read and check SO release
    sel();
    xfer(8'h52, rx); xfer(8'h92, rx);
    bit_x(1'b0, r); bit_x(1'b0, r); bit_x(1'b0, r);
    cs_n = 1'b1;
    #(HALF);
    check(so_oe == 1'b0, "R11 SO released on deselect", 32'(so_oe), 0);
    #(8*HALF);
    c0 = m_cnt;
    sel();
    xfer(8'h52, rx); xfer(8'hA0, rx); xfer(8'h0F, rx);
    desel();
    check(m_cnt - c0 == 1 && m_data == 8'h0F, "R11 fresh frame after abort", 32'(m_data), 32'h0F);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule